// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings up and shuts down the supplies of a small TFT LCD panel in a fixed, timed order. It also opens and closes the panel's control gate. It drives five enables: the logic rail, the negative gate-voltage rail, the positive gate-voltage rail, the 5 V rail and the panel-control enable. All waits are counted in ticks of a free-running 1 ms strobe, so the rest of the chip may clock the block at any rate.

Two level requests steer it. `pwr_req` asks for the rails to be up and `disp_req` asks for the panel to be enabled. The block has only two resting states, rails-off and rails-on. Only in those states does it compare the requests against what it is currently driving and start the next sequence. A sequence that has started always runs to its end. Any request change seen during a sequence therefore waits as a pending level until the sequencer is idle again. Screen-on is done in this order: rails up, pixel controller started elsewhere, then panel enable. Screen-off is the reverse: panel off, pixel controller stopped, then rails down. `pwr_good` tells the pixel controller when it may run.

All pins are plain control and status signals. No data flows through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset every output is low (all five enables, `busy`, `pwr_good`) and the block rests in rails-off.
- R2: Power-up raises the logic rail at once, then the negative gate rail 30 ms later, then the positive gate rail 5 ms later, then the 5 V rail 50 ms later, and sets `pwr_good` 5 ms after that. At most one output changes per clock.
- R3: Power-down clears `pwr_good` at once, then drops the 5 V rail 5 ms later, the negative gate rail 50 ms later, the positive gate rail 5 ms later, and the logic rail 100 ms later. The negative gate rail always falls before the positive one.
- R4: From rails-on with `disp_req` high and the panel off, the panel enable rises after a 17 ms wait. That wait starts one clock after the sequencer entered rails-on.
- R5: From rails-on with `disp_req` low and the panel on, the panel enable falls at once. The sequencer then stays busy for 30 ms before it takes any further step.
- R6: `disp_req` has no effect while `pwr_good` is low. The panel enable stays low and the request is acted on once power-up has completed.
- R7: A power-down request while the panel is enabled first runs the panel-off sequence. `pwr_good` then falls 30 ms after the panel enable falls, and the rail shutdown follows without a return to rest.
- R8: No sequence is aborted. Request changes during a sequence are acted on only when it completes. If power is withdrawn during power-up, `pwr_good` is high for exactly one clock before power-down begins.
- R9: `busy` is low only in rails-off (all outputs low) and rails-on (all four rails and `pwr_good` high). It is high in every sequence.
- R10: A wait of N ms ends on the (N+1)-th `tick_ms` pulse after the step that started it. A tick in that step's own clock does not count. The wait therefore lasts more than N and at most N+1 tick periods.
- R11: The gate and 5 V rails are only ever on while the logic rail is on. The panel enable is only on while all four rails and `pwr_good` are on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-clock strobe every 1 ms |
| pwr_req | input | 1 | Level: rails wanted up |
| disp_req | input | 1 | Level: panel enable wanted |
| logic_en | output | 1 | Logic rail enable |
| vneg_en | output | 1 | Negative gate-voltage rail enable |
| vpos_en | output | 1 | Positive gate-voltage rail enable |
| v5_en | output | 1 | 5 V rail enable |
| panel_en | output | 1 | Panel-control enable |
| busy | output | 1 | A sequence is running |
| pwr_good | output | 1 | Power-up complete, pixel controller may run |

## Verification
The assertions check the following on every cycle: rail dependencies, the rise and fall order of the two gate rails, single-output changes per clock, the consistency of `busy` with the resting output patterns, and that a running wait is never restarted or left early. Only the bench's scenarios can show the delays themselves: the 30/5/50/5 and 5/50/5/100 ms gaps, the 17 ms and 30 ms panel waits, a panel request pending through power-up, panel-off run ahead of power-down, and a power withdrawal in mid power-up. The bench measures each gap in tick periods and also compares every output against a behavioural model on every clock.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_UP,
    ST_ON,
    ST_PNL_ON,
    ST_PNL_OFF,
    ST_DOWN
  } seq_st_e;

  typedef struct packed {
    logic good;
    logic panel;
    logic v5;
    logic vpos;
    logic vneg;
    logic logic_on;
  } drv_t;

  localparam int unsigned STEPS = 4;
  localparam int unsigned STEP_W = $clog2(STEPS);

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcdseq_wait.sv
module lcdseq_wait #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          done
);

  logic [CW-1:0] cnt;
  logic          armed;

  assign done = armed && tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (start) begin
      cnt   <= len;
      armed <= 1'b1;
    end else if (armed && tick) begin
      if (cnt == '0) armed <= 1'b0;
      else           cnt   <= cnt - 1'b1;
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!armed || done)); // R8

  AST_DONE_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !tick && !start) |=> armed); // R10

endmodule

// File: rtl/lcdseq_ctrl.sv
module lcdseq_ctrl
  import lcdseq_pkg::*;
#(
  parameter int unsigned UP_D0  = 30,
  parameter int unsigned UP_D1  = 5,
  parameter int unsigned UP_D2  = 50,
  parameter int unsigned UP_D3  = 5,
  parameter int unsigned DN_D0  = 5,
  parameter int unsigned DN_D1  = 50,
  parameter int unsigned DN_D2  = 5,
  parameter int unsigned DN_D3  = 100,
  parameter int unsigned PON_D  = 17,
  parameter int unsigned POFF_D = 30,
  parameter int unsigned CW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_req,
  input  logic          disp_req,
  input  logic          done,
  output logic          start,
  output logic [CW-1:0] len,
  output drv_t          drv,
  output logic          busy
);

  seq_st_e           st, st_n;
  logic [STEP_W-1:0] step, step_n;
  drv_t              drv_n;

  always_comb begin
    st_n   = st;
    step_n = step;
    drv_n  = drv;
    start  = 1'b0;
    len    = '0;
    unique case (st)
      ST_OFF: if (pwr_req) begin
        st_n           = ST_UP;
        step_n         = '0;
        drv_n.logic_on = 1'b1;
        start          = 1'b1;
        len            = CW'(UP_D0);
      end
      ST_UP: if (done) begin
        start  = 1'b1;
        step_n = step + 1'b1;
        unique case (step)
          2'd0: begin drv_n.vneg = 1'b1; len = CW'(UP_D1); end
          2'd1: begin drv_n.vpos = 1'b1; len = CW'(UP_D2); end
          2'd2: begin drv_n.v5   = 1'b1; len = CW'(UP_D3); end
          default: begin
            drv_n.good = 1'b1;
            start      = 1'b0;
            st_n       = ST_ON;
          end
        endcase
      end
      ST_ON: begin
        if (drv.panel && (!pwr_req || !disp_req)) begin
          st_n        = ST_PNL_OFF;
          drv_n.panel = 1'b0;
          start       = 1'b1;
          len         = CW'(POFF_D);
        end else if (!pwr_req) begin
          st_n       = ST_DOWN;
          step_n     = '0;
          drv_n.good = 1'b0;
          start      = 1'b1;
          len        = CW'(DN_D0);
        end else if (disp_req && !drv.panel) begin
          st_n  = ST_PNL_ON;
          start = 1'b1;
          len   = CW'(PON_D);
        end
      end
      ST_PNL_ON: if (done) begin
        st_n        = ST_ON;
        drv_n.panel = 1'b1;
      end
      ST_PNL_OFF: if (done) begin
        if (!pwr_req) begin
          st_n       = ST_DOWN;
          step_n     = '0;
          drv_n.good = 1'b0;
          start      = 1'b1;
          len        = CW'(DN_D0);
        end else begin
          st_n = ST_ON;
        end
      end
      ST_DOWN: if (done) begin
        start  = 1'b1;
        step_n = step + 1'b1;
        unique case (step)
          2'd0: begin drv_n.v5   = 1'b0; len = CW'(DN_D1); end
          2'd1: begin drv_n.vneg = 1'b0; len = CW'(DN_D2); end
          2'd2: begin drv_n.vpos = 1'b0; len = CW'(DN_D3); end
          default: begin
            drv_n.logic_on = 1'b0;
            start          = 1'b0;
            st_n           = ST_OFF;
          end
        endcase
      end
      default: st_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_OFF;
      step <= '0;
      drv  <= '0;
    end else begin
      st   <= st_n;
      step <= step_n;
      drv  <= drv_n;
    end
  end

  assign busy = (st != ST_OFF) && (st != ST_ON);

  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (st == $past(st))); // R8

  AST_IDLE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((drv == '0) ||
               (drv.good && drv.logic_on && drv.vneg && drv.vpos && drv.v5))); // R9

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcdseq_pkg::*;
#(
  parameter int unsigned UP_D0  = 30,
  parameter int unsigned UP_D1  = 5,
  parameter int unsigned UP_D2  = 50,
  parameter int unsigned UP_D3  = 5,
  parameter int unsigned DN_D0  = 5,
  parameter int unsigned DN_D1  = 50,
  parameter int unsigned DN_D2  = 5,
  parameter int unsigned DN_D3  = 100,
  parameter int unsigned PON_D  = 17,
  parameter int unsigned POFF_D = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic pwr_req,
  input  logic disp_req,
  output logic logic_en,
  output logic vneg_en,
  output logic vpos_en,
  output logic v5_en,
  output logic panel_en,
  output logic busy,
  output logic pwr_good
);

  localparam int unsigned MAX_UP = max_u(max_u(UP_D0, UP_D1), max_u(UP_D2, UP_D3));
  localparam int unsigned MAX_DN = max_u(max_u(DN_D0, DN_D1), max_u(DN_D2, DN_D3));
  localparam int unsigned MAX_D  = max_u(max_u(MAX_UP, MAX_DN), max_u(PON_D, POFF_D));
  localparam int unsigned CW     = $clog2(MAX_D + 1);

  logic          w_start;
  logic          w_done;
  logic [CW-1:0] w_len;
  drv_t          drv;

  lcdseq_wait #(.CW(CW)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_ms),
    .start (w_start),
    .len   (w_len),
    .done  (w_done)
  );

  lcdseq_ctrl #(
    .UP_D0(UP_D0), .UP_D1(UP_D1), .UP_D2(UP_D2), .UP_D3(UP_D3),
    .DN_D0(DN_D0), .DN_D1(DN_D1), .DN_D2(DN_D2), .DN_D3(DN_D3),
    .PON_D(PON_D), .POFF_D(POFF_D), .CW(CW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_req  (pwr_req),
    .disp_req (disp_req),
    .done     (w_done),
    .start    (w_start),
    .len      (w_len),
    .drv      (drv),
    .busy     (busy)
  );

  assign logic_en = drv.logic_on;
  assign vneg_en  = drv.vneg;
  assign vpos_en  = drv.vpos;
  assign v5_en    = drv.v5;
  assign panel_en = drv.panel;
  assign pwr_good = drv.good;

  AST_GATES_NEED_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
    (vneg_en || vpos_en || v5_en) |-> logic_en); // R11

  AST_PANEL_NEEDS_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
    panel_en |-> (pwr_good && logic_en && vneg_en && vpos_en && v5_en)); // R11

  AST_POS_AFTER_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpos_en) |-> vneg_en); // R2

  AST_NEG_FALLS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vpos_en) |-> (!vneg_en && !v5_en)); // R3

  AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({logic_en, vneg_en, vpos_en, v5_en, panel_en, pwr_good} ^
               $past({logic_en, vneg_en, vpos_en, v5_en, panel_en, pwr_good})) <= 1); // R2

  AST_PANEL_WAITS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_en) |-> $past(pwr_good)); // R6

endmodule

// File: tb/lcd_pwr_seq_tb.sv
module lcd_pwr_seq_tb;

  localparam int TP = 10; // clock cycles per ms tick

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic pwr_req = 1'b0;
  logic disp_req = 1'b0;
  logic logic_en, vneg_en, vpos_en, v5_en, panel_en, busy, pwr_good;

  always #5 clk = ~clk;

  lcd_pwr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pwr_req(pwr_req), .disp_req(disp_req),
    .logic_en(logic_en), .vneg_en(vneg_en), .vpos_en(vpos_en), .v5_en(v5_en),
    .panel_en(panel_en), .busy(busy), .pwr_good(pwr_good)
  );

  // observed vector: [0] logic [1] neg [2] pos [3] 5V [4] panel [5] good
  logic [5:0] obs;
  assign obs = {pwr_good, panel_en, v5_en, vpos_en, vneg_en, logic_en};

  int chk_n = 0;
  int fail_n = 0;
  longint cyc = 0;
  bit cmp_on = 1'b0;
  longint rise_t[6];
  longint fall_t[6];
  logic [5:0] prev_obs = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    chk_n++;
    if (!ok) begin
      fail_n++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic chk_gap(input string req, input string what, input longint t0,
                         input longint t1, input int n, input int extra);
    longint d = t1 - t0;
    check((d > longint'(n * TP + extra)) && (d <= longint'((n + 1) * TP + extra)),
          req, what, d, longint'((n + 1) * TP + extra));
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  int tcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin tcnt = 0; tick_ms = 1'b0; end
    else begin tcnt++; tick_ms = ((tcnt % TP) == 0); end
  end

  // behavioural reference: mode 0 off, 1 up, 2 on, 3 panel-on wait, 4 panel-off wait, 5 down
  int m_mode, m_step, m_rem;
  bit m_log, m_neg, m_pos, m_v5, m_pnl, m_good;
  always @(posedge clk) begin
    bit fin;
    if (!rst_n) begin
      m_mode = 0; m_step = 0; m_rem = 0;
      {m_log, m_neg, m_pos, m_v5, m_pnl, m_good} = '0;
    end else begin
      fin = 1'b0;
      if (m_mode != 0 && m_mode != 2 && tick_ms) begin
        if (m_rem == 1) fin = 1'b1; else m_rem--;
      end
      case (m_mode)
        0: if (pwr_req) begin m_mode = 1; m_step = 0; m_log = 1; m_rem = 31; end
        1: if (fin) begin
          case (m_step)
            0: begin m_neg = 1; m_rem = 6; end
            1: begin m_pos = 1; m_rem = 51; end
            2: begin m_v5 = 1; m_rem = 6; end
            default: begin m_good = 1; m_mode = 2; end
          endcase
          m_step++;
        end
        2: begin
          if (m_pnl && (!pwr_req || !disp_req)) begin m_pnl = 0; m_mode = 4; m_rem = 31; end
          else if (!pwr_req) begin m_mode = 5; m_step = 0; m_good = 0; m_rem = 6; end
          else if (disp_req && !m_pnl) begin m_mode = 3; m_rem = 18; end
        end
        3: if (fin) begin m_pnl = 1; m_mode = 2; end
        4: if (fin) begin
          if (!pwr_req) begin m_mode = 5; m_step = 0; m_good = 0; m_rem = 6; end
          else m_mode = 2;
        end
        5: if (fin) begin
          case (m_step)
            0: begin m_v5 = 0; m_rem = 51; end
            1: begin m_neg = 0; m_rem = 6; end
            2: begin m_pos = 0; m_rem = 101; end
            default: begin m_log = 0; m_mode = 0; end
          endcase
          m_step++;
        end
        default: m_mode = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    logic [6:0] exp_v, act_v;
    if (cmp_on) begin
      exp_v = {(m_mode != 0 && m_mode != 2), m_good, m_pnl, m_v5, m_pos, m_neg, m_log};
      act_v = {busy, obs};
      chk_n++;
      if (act_v !== exp_v) begin
        fail_n++;
        if (act_v[6] !== exp_v[6])
          $display("FAIL R9 model busy at cycle %0d: actual %b expected %b", cyc, act_v, exp_v);
        else if (act_v[4] !== exp_v[4])
          $display("FAIL R4 R5 model panel at cycle %0d: actual %b expected %b", cyc, act_v, exp_v);
        else
          $display("FAIL R2 R3 R10 model rails at cycle %0d: actual %b expected %b", cyc, act_v, exp_v);
      end
    end
    for (int i = 0; i < 6; i++) begin
      if (obs[i] && !prev_obs[i]) rise_t[i] = cyc;
      if (!obs[i] && prev_obs[i]) fall_t[i] = cyc;
    end
    prev_obs = obs;
  end

  task automatic wait_bit(input int idx, input bit val);
    do begin @(negedge clk); #1; end while (obs[idx] !== val);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail_n++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    longint t_a, t_drop;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk); #1;
    check(obs == '0, "R1", "outputs after reset", obs, 0);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);

    // R6: panel request with rails off has no effect
    disp_req = 1'b1;
    repeat (30) @(negedge clk); #1;
    check(panel_en == 1'b0, "R6", "panel while off", panel_en, 0);
    check(busy == 1'b0, "R6", "busy while off", busy, 0);

    // R2/R10: power-up with the panel request already pending
    pwr_req = 1'b1;
    wait_bit(5, 1'b1);
    check(panel_en == 1'b0, "R6", "panel at power-good", panel_en, 0);
    chk_gap("R2", "logic->neg gap", rise_t[0], rise_t[1], 30, 0);
    chk_gap("R2", "neg->pos gap", rise_t[1], rise_t[2], 5, 0);
    chk_gap("R2", "pos->5V gap", rise_t[2], rise_t[3], 50, 0);
    chk_gap("R10", "5V->good gap", rise_t[3], rise_t[5], 5, 0);
    wait_bit(4, 1'b1);
    chk_gap("R4", "good->panel gap", rise_t[5], rise_t[4], 17, 1);
    check(busy == 1'b0, "R9", "busy at idle-on", busy, 0);

    // R5/R8: panel off, then re-request during the 30 ms hold
    disp_req = 1'b0;
    wait_bit(4, 1'b0);
    check(busy == 1'b1, "R5", "busy after panel off", busy, 1);
    repeat (3) @(negedge clk); #1;
    disp_req = 1'b1;
    wait_bit(4, 1'b1);
    t_a = rise_t[4] - fall_t[4];
    check((t_a > longint'(47 * TP + 1)) && (t_a <= longint'(49 * TP + 1)),
          "R5", "panel off->on total", t_a, 49 * TP + 1);
    check(pwr_good == 1'b1, "R8", "rails kept during panel cycle", pwr_good, 1);

    // R7/R3: power-down with the panel on
    pwr_req = 1'b0;
    wait_bit(0, 1'b0);
    chk_gap("R7", "panel->good fall gap", fall_t[4], fall_t[5], 30, 0);
    chk_gap("R3", "good->5V fall gap", fall_t[5], fall_t[3], 5, 0);
    chk_gap("R3", "5V->neg fall gap", fall_t[3], fall_t[1], 50, 0);
    chk_gap("R3", "neg->pos fall gap", fall_t[1], fall_t[2], 5, 0);
    chk_gap("R3", "pos->logic fall gap", fall_t[2], fall_t[0], 100, 0);
    check(fall_t[1] < fall_t[2], "R3", "neg falls before pos", fall_t[1], fall_t[2]);
    @(negedge clk); #1;
    check(obs == '0 && busy == 1'b0, "R9", "idle-off pattern", {busy, obs}, 0);

    // R8: power withdrawn in mid power-up
    disp_req = 1'b0;
    pwr_req = 1'b1;
    repeat (10 * TP) @(negedge clk); #1;
    pwr_req = 1'b0;
    t_drop = cyc;
    wait_bit(5, 1'b1);
    check(rise_t[3] > t_drop, "R8", "5V rose after withdrawal", rise_t[3], t_drop + 1);
    wait_bit(0, 1'b0);
    check(fall_t[5] - rise_t[5] == 1, "R8", "good high one clock", fall_t[5] - rise_t[5], 1);
    check(fall_t[1] < fall_t[2], "R3", "neg before pos again", fall_t[1], fall_t[2]);
    repeat (5) @(negedge clk); #1;
    check(obs == '0, "R1", "final outputs", obs, 0);
    summary();
  end

endmodule